// File: doc/BRIEF.md
# Pixel Alpha and Channel Modifier

This is a streaming stage in a pixel pipeline. It accepts one 32-bit pixel per cycle under a valid/ready handshake and produces the adjusted pixel on the next cycle. The pixel word is packed with alpha in bits [31:24], red in [23:16], green in [15:8] and blue in [7:0]. A 2-bit mode input sets the alpha policy. The incoming alpha can pass through unchanged, be replaced by an 8-bit constant, or be scaled by that constant over 255 with rounding. Two flag inputs adjust the result further. One takes the ones' complement of every alpha value before the policy is applied. The other exchanges the red and blue bytes.

The same two transforms are also available on two combinational side paths. One takes a 32-bit colour-table entry and the other takes a 24-bit constant colour. Upstream logic can use them to bring table contents and fill colours into the same alpha sense and channel order that the pixel stream uses. Configuration is read in the cycle a pixel is accepted, so a change of configuration affects only pixels accepted after it.

Top module: `px_alpha_stage`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With mode 0, the output alpha equals the incoming alpha, after inversion when the invert flag is set.
- R3: With mode 1, the output alpha equals the constant alpha, after inversion when the invert flag is set.
- R4: With mode 2, the output alpha equals the rounded value of (incoming alpha × constant alpha) / 255, where both operands are taken after any inversion. A constant of 255 returns the incoming alpha exactly, and a constant of 0 returns 0.
- R5: Mode 3 behaves exactly like mode 0.
- R6: When the invert flag is set, the incoming alpha and the constant alpha are each replaced by 255 minus their value before the mode is applied.
- R7: When the swap flag is set, the output bits [23:16] and [7:0] carry the input bits [7:0] and [23:16]. Green in bits [15:8] is never altered. With the flag clear, the colour bytes pass unchanged.
- R8: A pixel accepted on a clock edge (`in_valid` and `in_ready` both high) appears on the output with `out_valid` high after that edge. Pixels leave in the order they were accepted, and none is lost or repeated.
- R9: While `out_valid` is high and `out_ready` is low, the output pixel stays stable and `in_ready` is low. Otherwise `in_ready` is high.
- R10: `lut_entry_out` equals `lut_entry_in` with its alpha in bits [31:24] inverted when the invert flag is set and with the red/blue swap of R7 applied. It updates in the same cycle as its input.
- R11: `const_rgb_out` equals `const_rgb_in` with bits [23:16] and [7:0] exchanged when the swap flag is set. Bits [15:8] pass unchanged. It updates in the same cycle as its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_amode | input | 2 | Alpha policy: 0 keep, 1 replace, 2 scale, 3 keep |
| cfg_alpha | input | 8 | Constant alpha |
| cfg_ainv | input | 1 | Invert every alpha value |
| cfg_rbswap | input | 1 | Exchange red and blue |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage can take a pixel |
| in_pixel | input | 32 | Input pixel, packed as alpha, red, green, blue from MSB to LSB |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 32 | Adjusted pixel |
| lut_entry_in | input | 32 | Colour-table entry to normalise |
| lut_entry_out | output | 32 | Normalised table entry |
| const_rgb_in | input | 24 | Constant colour to normalise |
| const_rgb_out | output | 24 | Normalised constant colour |

## Verification
Two things can happen in the same cycle. A new pixel can be captured while the held pixel is being drained, and the downstream side can hold the output stage while the upstream side keeps offering data. The bench provokes these events in several ways. It drives `out_ready` randomly, and it also drives it permanently high to get back-to-back transfers. In other windows it holds `out_ready` low with a new pixel waiting at the input. A behavioural queue model predicts every transferred pixel and the handshake state on every cycle. Any lost, duplicated, reordered or changed pixel therefore appears as a mismatch, as does one captured under stale configuration.

// File: rtl/px_pkg.sv
package px_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 4 * CH_W;
  localparam int RGB_W = 3 * CH_W;
  localparam int PRD_W = 2 * CH_W;

  typedef enum logic [1:0] {
    AM_KEEP    = 2'd0,
    AM_REPLACE = 2'd1,
    AM_SCALE   = 2'd2,
    AM_RSVD    = 2'd3
  } amode_e;

  // optional ones' complement of an alpha value
  function automatic logic [CH_W-1:0] f_inv(input logic [CH_W-1:0] a, input logic en);
    return en ? ~a : a;
  endfunction

  // rounded division of a product by 255
  function automatic logic [CH_W-1:0] f_div255(input logic [PRD_W-1:0] x);
    logic [PRD_W:0] t;
    logic [PRD_W:0] s;
    t = {1'b0, x} + (PRD_W+1)'(128);
    s = t + (t >> CH_W);
    return s[PRD_W-1:CH_W];
  endfunction

  // exchange the outer colour bytes of a 24-bit colour
  function automatic logic [RGB_W-1:0] f_rgb_swap(input logic [RGB_W-1:0] c, input logic en);
    return en ? {c[CH_W-1:0], c[2*CH_W-1:CH_W], c[RGB_W-1:2*CH_W]} : c;
  endfunction
endpackage

// File: rtl/px_alpha_unit.sv
module px_alpha_unit
  import px_pkg::*;
(
  input  logic [1:0]      amode,
  input  logic [CH_W-1:0] cst_alpha,
  input  logic            ainv,
  input  logic [CH_W-1:0] alpha_in,
  output logic [CH_W-1:0] alpha_out
);
  logic [CH_W-1:0]  eff_in;
  logic [CH_W-1:0]  eff_cst;
  logic [PRD_W-1:0] prod;
  logic [CH_W-1:0]  scaled;
  amode_e           mode;

  assign eff_in  = f_inv(alpha_in, ainv);
  assign eff_cst = f_inv(cst_alpha, ainv);
  assign prod    = PRD_W'(eff_in) * PRD_W'(eff_cst);
  assign scaled  = f_div255(prod);
  assign mode    = amode_e'(amode);

  always_comb begin
    unique case (mode)
      AM_REPLACE: alpha_out = eff_cst;
      AM_SCALE:   alpha_out = scaled;
      default:    alpha_out = eff_in;
    endcase
  end
endmodule

// File: rtl/px_chan_swap.sv
module px_chan_swap #(
  parameter int W = 8
) (
  input  logic [4*W-1:0] word_in,
  input  logic           swap_en,
  output logic [4*W-1:0] word_out
);
  localparam int LANES = 4;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lanes 0 and 2 trade places, lanes 1 and 3 stay
    localparam int ALT = (g == 0) ? 2 : (g == 2) ? 0 : g;
    assign word_out[g*W +: W] = swap_en ? word_in[ALT*W +: W] : word_in[g*W +: W];
  end
endmodule

// File: rtl/px_stage_reg.sv
module px_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load)     out_data  <= in_data;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && out_data == $past(in_data)); // R8
endmodule

// File: rtl/px_alpha_stage.sv
module px_alpha_stage
  import px_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_amode,
  input  logic [CH_W-1:0]  cfg_alpha,
  input  logic             cfg_ainv,
  input  logic             cfg_rbswap,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel,
  input  logic [PIX_W-1:0] lut_entry_in,
  output logic [PIX_W-1:0] lut_entry_out,
  input  logic [RGB_W-1:0] const_rgb_in,
  output logic [RGB_W-1:0] const_rgb_out
);
  logic [CH_W-1:0]  px_alpha;
  logic [PIX_W-1:0] px_swapped;
  logic [PIX_W-1:0] px_next;
  logic [PIX_W-1:0] lut_pre;
  logic             accept;
  logic [CH_W-1:0]  cst_seen;

  // stream path: alpha policy, channel order, one register
  px_alpha_unit u_alpha (
    .amode     (cfg_amode),
    .cst_alpha (cfg_alpha),
    .ainv      (cfg_ainv),
    .alpha_in  (in_pixel[PIX_W-1 -: CH_W]),
    .alpha_out (px_alpha)
  );

  px_chan_swap #(.W(CH_W)) u_px_swap (
    .word_in  (in_pixel),
    .swap_en  (cfg_rbswap),
    .word_out (px_swapped)
  );

  assign px_next = {px_alpha, px_swapped[RGB_W-1:0]};

  px_stage_reg #(.W(PIX_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (px_next),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_pixel)
  );

  // side paths for table entries and the constant colour
  assign lut_pre = {f_inv(lut_entry_in[PIX_W-1 -: CH_W], cfg_ainv), lut_entry_in[RGB_W-1:0]};

  px_chan_swap #(.W(CH_W)) u_lut_swap (
    .word_in  (lut_pre),
    .swap_en  (cfg_rbswap),
    .word_out (lut_entry_out)
  );

  assign const_rgb_out = f_rgb_swap(const_rgb_in, cfg_rbswap);

  // observation wires for the checks below
  assign accept   = in_valid && in_ready;
  assign cst_seen = cfg_ainv ? (8'hFF - cfg_alpha) : cfg_alpha;

  AST_GREEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_pixel[2*CH_W-1:CH_W] == $past(in_pixel[2*CH_W-1:CH_W])); // R7
  AST_REPLACE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_amode == 2'd1 |=> out_pixel[PIX_W-1 -: CH_W] == $past(cst_seen)); // R3
  AST_SCALE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_amode == 2'd2 && cst_seen == 8'd0 |=> out_pixel[PIX_W-1 -: CH_W] == 8'd0); // R4
  AST_SCALE_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cfg_amode == 2'd2 && cst_seen == 8'hFF
    |=> out_pixel[PIX_W-1 -: CH_W] == $past(cfg_ainv ? ~in_pixel[PIX_W-1 -: CH_W]
                                                       : in_pixel[PIX_W-1 -: CH_W])); // R4
  AST_LUT_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    lut_entry_out[2*CH_W-1:CH_W] == lut_entry_in[2*CH_W-1:CH_W]); // R10
endmodule

// File: tb/px_alpha_stage_test.sv
module px_alpha_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_amode = 2'd0;
  logic [7:0]  cfg_alpha = 8'd0;
  logic        cfg_ainv = 1'b0;
  logic        cfg_rbswap = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixel;
  logic [31:0] lut_entry_in = 32'd0;
  logic [31:0] lut_entry_out;
  logic [23:0] const_rgb_in = 24'd0;
  logic [23:0] const_rgb_out;

  int checks = 0;
  int errors = 0;
  int rmode = 0;      // 0 hold low, 1 always high, 2 random
  int cycles = 0;
  logic [31:0] qd[$];
  string       qt[$];

  always #5 clk = ~clk;

  px_alpha_stage uut (.*);

  function automatic logic [31:0] model(input logic [31:0] p, input int m, input int c,
                                        input bit inv, input bit sw);
    int a = p[31:24];
    int k = c;
    logic [7:0] r, b, ao;
    if (inv) begin a = 255 - a; k = 255 - c; end
    if (m == 1) a = k;
    else if (m == 2) a = (a * k + 127) / 255;
    ao = a[7:0];
    r = sw ? p[7:0] : p[23:16];
    b = sw ? p[23:16] : p[7:0];
    return {ao, r, p[15:8], b};
  endfunction

  function automatic string tag_of(input int m, input bit inv, input bit sw);
    string t;
    t = (m == 1) ? "R3" : (m == 2) ? "R4" : (m == 3) ? "R5" : "R2";
    if (inv) t = {t, "/R6"};
    if (sw)  t = {t, "/R7"};
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, compared every cycle away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == (qd.size() != 0), "R8 valid", 32'(out_valid), 32'(qd.size() != 0));
      chk(in_ready == (!out_valid || out_ready), "R9 ready", 32'(in_ready),
          32'(!out_valid || out_ready));
      if (out_valid && qd.size() != 0)
        chk(out_pixel == qd[0], {qt[0], "/R8/R9 data"}, out_pixel, qd[0]);
      chk(lut_entry_out == model(lut_entry_in, 0, 0, cfg_ainv, cfg_rbswap), "R10 lut",
          lut_entry_out, model(lut_entry_in, 0, 0, cfg_ainv, cfg_rbswap));
      chk({8'd0, const_rgb_out} == model({8'd0, const_rgb_in}, 0, 0, 1'b0, cfg_rbswap) & 32'hFFFFFF,
          "R11 const", {8'd0, const_rgb_out},
          model({8'd0, const_rgb_in}, 0, 0, 1'b0, cfg_rbswap) & 32'hFFFFFF);
      if (out_valid && out_ready && qd.size() != 0) begin
        void'(qd.pop_front());
        void'(qt.pop_front());
      end
      if (in_valid && in_ready) begin
        qd.push_back(model(in_pixel, int'(cfg_amode), int'(cfg_alpha), cfg_ainv, cfg_rbswap));
        qt.push_back(tag_of(int'(cfg_amode), cfg_ainv, cfg_rbswap));
      end
    end
  end

  // downstream ready and side-path stimulus
  initial begin
    forever begin
      @(posedge clk); #2;
      out_ready    = (rmode == 1) ? 1'b1 : (rmode == 2) ? ($urandom % 4 != 0) : 1'b0;
      lut_entry_in = $urandom;
      const_rgb_in = 24'($urandom);
    end
  end

  task automatic send(input logic [31:0] p);
    in_valid = 1'b1;
    in_pixel = p;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    @(posedge clk); #2;
    rst_n = 1'b1;
    rmode = 2;

    // every mode, flag combination, random traffic
    for (int m = 0; m < 4; m++)
      for (int inv = 0; inv < 2; inv++)
        for (int sw = 0; sw < 2; sw++) begin
          cfg_amode  = 2'(m);
          cfg_ainv   = inv[0];
          cfg_rbswap = sw[0];
          cfg_alpha  = 8'($urandom);
          for (int k = 0; k < 12; k++) begin
            send($urandom);
            if ($urandom % 3 == 0) idle(1);
          end
        end

    // scaling corners: constant 255 is identity, constant 0 gives zero
    rmode = 1;
    cfg_amode = 2'd2; cfg_ainv = 1'b0; cfg_rbswap = 1'b0;
    cfg_alpha = 8'hFF;
    send(32'h00123456); send(32'hFF123456); send(32'h80ABCDEF); send(32'h01010101);
    cfg_alpha = 8'h00;
    send(32'hC8112233); send(32'hFF445566);
    cfg_ainv = 1'b1; cfg_alpha = 8'h00;   // inverted constant becomes 255
    send(32'h3C778899); send(32'h00AA00BB);
    cfg_alpha = 8'h80; cfg_ainv = 1'b0;
    send(32'h7FFFFFFF); send(32'h81000000);

    // stall: output held while a new pixel waits
    cfg_amode = 2'd1; cfg_alpha = 8'h5A; cfg_rbswap = 1'b1;
    rmode = 0;
    idle(2);
    send(32'h11223344);
    in_valid = 1'b1; in_pixel = 32'h55667788;
    idle(6);
    rmode = 1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;

    // back-to-back transfers while draining
    cfg_amode = 2'd3; cfg_ainv = 1'b1;
    for (int k = 0; k < 8; k++) send($urandom);
    idle(4);
    rmode = 2;
    idle(20);
    finish_run();
  end
endmodule